// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This unit turns the operands of an 8/16-bit processor core into 24-bit bus addresses. Data references combine a data bank byte with a 16-bit operand and, optionally, an index register. Indirect jump pointers are formed in bank zero. Program fetches combine a program bank byte with a program counter that the block holds. Stack references go through a stack pointer that the block also holds. A mode flag selects between a native stack, which spans the full 16 bits, and an emulation stack, which is kept in page one.

Each kind of address wraps at its own boundary. Data addresses carry all the way into the bank byte. Pointer and program addresses wrap within 16 bits, and the program bank is never changed. The emulation stack wraps inside page one for the classic push and pull operations. The extended push and pull operations step the full 16-bit pointer first and only then pin the high byte back to page one. The core's sequencer drives a mode select, a byte offset for multi-byte accesses, and stack and program-counter operations every cycle. It reads back the address at once, and the updated pointers after the next clock edge. A small output reports the fixed cycle counts of two instruction forms whose timing does not depend on page crossing.

Top module: `eag_top`

## Requirements
- R1: With mode_sel=0 (absolute), addr equals the 24-bit value {dbank, operand} plus byte_off, and a carry propagates into the bank byte (bank $12, operand $FFFF, offset 1 gives $130000).
- R2: With mode_sel=1 (indexed by idx_x) or mode_sel=2 (indexed by idx_y), addr equals {dbank, operand} + index + byte_off modulo 2^24, with full carry into the bank byte (bank $00, operand $FFFF, index 1 gives $010000).
- R3: With mode_sel=3 (jump pointer), addr equals {$00, (operand + byte_off) mod 2^16}, so a pointer at $12FF takes its second byte from $001300. fixed_cyc reads 5 in this mode while emu=1, and 0 while emu=0.
- R4: pc_op=1 increments the program counter, pc_op=2 adds the sign-extended operand[7:0], and pc_op=3 loads operand. All of these wrap modulo 2^16. With mode_sel=5, addr equals {pbank, (pc_out + byte_off) mod 2^16}.
- R5: With mode_sel=4 (stack), addr[23:16] is always $00. While emu=1, sp_out[15:8] reads $01 from the clock edge after emu is sampled high.
- R6: While emu=1 with stk_ext=0, stk_op=1 (push) addresses $0001ss and then leaves S=$01(ss-1 mod 256). stk_op=2 (pull) sets S=$01(ss+1 mod 256) and addresses that new value.
- R7: While emu=1 with stk_ext=1, push and pull step the full 16-bit pointer and then force the high byte to $01. From S=$0100, a push addresses $000100 and leaves $01FF, and the next pull addresses $000200 and leaves $0100.
- R8: While emu=0, a push addresses S and then sets S to S-1 mod 2^16. A pull sets S to S+1 mod 2^16 and addresses the new S. stk_op=3 loads S from operand in both modes, with the high byte forced to $01 while emu=1.
- R9: fixed_cyc reads 7 when mode_sel=1 and rmw=1. In every other case apart from R3 it reads 0.
- R10: While rst_n is low, pc_out is $0000 and sp_out is $01FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Address form: 0 abs, 1 abs+X, 2 abs+Y, 3 pointer, 4 stack, 5 program |
| operand | input | 16 | Instruction operand |
| idx_x | input | 16 | First index register |
| idx_y | input | 16 | Second index register |
| dbank | input | 8 | Data bank byte |
| pbank | input | 8 | Program bank byte |
| emu | input | 1 | Emulation mode flag |
| byte_off | input | 2 | Byte offset within a multi-byte access |
| stk_op | input | 2 | 0 none, 1 push, 2 pull, 3 load |
| stk_ext | input | 1 | Selects extended push/pull behaviour in emulation mode |
| pc_op | input | 2 | 0 hold, 1 increment, 2 relative branch, 3 load |
| rmw | input | 1 | Current instruction is read-modify-write |
| addr | output | 24 | Effective bus address |
| sp_out | output | 16 | Stack pointer register |
| pc_out | output | 16 | Program counter register |
| fixed_cyc | output | 3 | Fixed cycle count for the two timing-fixed forms, else 0 |

## Verification
The bench sweeps banks, operands near page and bank edges, index values and byte offsets. A design that cut the carry at the bank byte would leave $12FFFF+1 in bank $12, and one that reproduced the page-wrap quirk would fetch the pointer's high byte from $1200. Program-counter runs cross $FFFF, and an incorrect design would carry into the program bank or fail to wrap backward branches. Stack runs start from $0100 and $0000 in both modes. They separate the page-one wrap from the extended-operation $000200 read, which a design with a single wrap rule cannot produce, and from the native wrap down to $FFFF.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    AM_ABS  = 3'd0,
    AM_ABSX = 3'd1,
    AM_ABSY = 3'd2,
    AM_PTR  = 3'd3,
    AM_STK  = 3'd4,
    AM_PRG  = 3'd5
  } am_e;

  typedef enum logic [1:0] {
    SO_NONE = 2'd0,
    SO_PUSH = 2'd1,
    SO_PULL = 2'd2,
    SO_LOAD = 2'd3
  } so_e;

  typedef enum logic [1:0] {
    PO_HOLD = 2'd0,
    PO_INC  = 2'd1,
    PO_REL  = 2'd2,
    PO_LOAD = 2'd3
  } po_e;

  localparam logic [2:0] CYC_PTR_EMU = 3'd5;
  localparam logic [2:0] CYC_RMW_IDX = 3'd7;
endpackage

// File: rtl/eag_data_addr.sv
module eag_data_addr
  import eag_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int BO_W   = 2
) (
  input  am_e                      mode,
  input  logic [OFF_W-1:0]         operand,
  input  logic [OFF_W-1:0]         idx_x,
  input  logic [OFF_W-1:0]         idx_y,
  input  logic [BANK_W-1:0]        dbank,
  input  logic [BO_W-1:0]          byte_off,
  output logic [BANK_W+OFF_W-1:0]  addr
);
  localparam int AW = BANK_W + OFF_W;

  logic [AW-1:0]    base_long;
  logic [AW-1:0]    idx_long;
  logic [AW-1:0]    off_long;
  logic [OFF_W-1:0] ptr_short;

  always_comb begin
    base_long = {dbank, operand};
    off_long  = AW'(byte_off);
    unique case (mode)
      AM_ABSX: idx_long = AW'(idx_x);
      AM_ABSY: idx_long = AW'(idx_y);
      default: idx_long = '0;
    endcase
    ptr_short = operand + OFF_W'(byte_off);
    if (mode == AM_PTR) addr = {{BANK_W{1'b0}}, ptr_short};
    else                addr = base_long + idx_long + off_long;
  end
endmodule

// File: rtl/eag_stack.sv
module eag_stack
  import eag_pkg::*;
#(
  parameter int               OFF_W = 16,
  parameter logic [7:0]       PAGE  = 8'h01
) (
  input  logic [OFF_W-1:0] sp_q,
  input  logic             emu,
  input  so_e              op,
  input  logic             ext,
  input  logic [OFF_W-1:0] operand,
  output logic [OFF_W-1:0] sp_d,
  output logic             sp_en,
  output logic [OFF_W-1:0] stk_addr
);
  localparam int LO_W = OFF_W - 8;

  logic [OFF_W-1:0] eff;
  logic [OFF_W-1:0] nxt;
  logic             paged;

  always_comb begin
    eff   = emu ? {PAGE, sp_q[LO_W-1:0]} : sp_q;
    paged = emu && !ext;
    nxt      = eff;
    stk_addr = eff;
    unique case (op)
      SO_PUSH: begin
        stk_addr = eff;
        if (paged) nxt = {PAGE, eff[LO_W-1:0] - LO_W'(1)};
        else       nxt = eff - OFF_W'(1);
      end
      SO_PULL: begin
        if (paged) nxt = {PAGE, eff[LO_W-1:0] + LO_W'(1)};
        else       nxt = eff + OFF_W'(1);
        stk_addr = nxt;
      end
      SO_LOAD: nxt = operand;
      default: nxt = eff;
    endcase
    sp_d = emu ? {PAGE, nxt[LO_W-1:0]} : nxt;
    sp_en = (op != SO_NONE) || (emu && (sp_q[OFF_W-1:LO_W] != PAGE));
  end
endmodule

// File: rtl/eag_pc.sv
module eag_pc
  import eag_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int REL_W = 8
) (
  input  logic [OFF_W-1:0] pc_q,
  input  po_e              op,
  input  logic [OFF_W-1:0] operand,
  output logic [OFF_W-1:0] pc_d,
  output logic             pc_en
);
  logic [OFF_W-1:0] rel_ext;

  always_comb begin
    rel_ext = {{(OFF_W-REL_W){operand[REL_W-1]}}, operand[REL_W-1:0]};
    unique case (op)
      PO_INC:  pc_d = pc_q + OFF_W'(1);
      PO_REL:  pc_d = pc_q + rel_ext;
      PO_LOAD: pc_d = operand;
      default: pc_d = pc_q;
    endcase
    pc_en = (op != PO_HOLD);
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int         BANK_W   = 8,
  parameter int         OFF_W    = 16,
  parameter int         BO_W     = 2,
  parameter logic [7:0] STK_PAGE = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode_sel,
  input  logic [OFF_W-1:0]         operand,
  input  logic [OFF_W-1:0]         idx_x,
  input  logic [OFF_W-1:0]         idx_y,
  input  logic [BANK_W-1:0]        dbank,
  input  logic [BANK_W-1:0]        pbank,
  input  logic                     emu,
  input  logic [BO_W-1:0]          byte_off,
  input  logic [1:0]               stk_op,
  input  logic                     stk_ext,
  input  logic [1:0]               pc_op,
  input  logic                     rmw,
  output logic [BANK_W+OFF_W-1:0]  addr,
  output logic [OFF_W-1:0]         sp_out,
  output logic [OFF_W-1:0]         pc_out,
  output logic [2:0]               fixed_cyc
);
  localparam int AW = BANK_W + OFF_W;
  localparam logic [OFF_W-1:0] SP_RST = {STK_PAGE, {(OFF_W-8){1'b1}}};

  am_e mode;
  so_e sop;
  po_e pop;

  logic [OFF_W-1:0] sp_q, sp_d, stk_addr;
  logic             sp_en;
  logic [OFF_W-1:0] pc_q, pc_d;
  logic             pc_en;
  logic [AW-1:0]    data_addr;
  logic [OFF_W-1:0] prg_off;

  assign mode = am_e'(mode_sel);
  assign sop  = so_e'(stk_op);
  assign pop  = po_e'(pc_op);

  eag_data_addr #(.BANK_W(BANK_W), .OFF_W(OFF_W), .BO_W(BO_W)) u_data (
    .mode(mode), .operand(operand), .idx_x(idx_x), .idx_y(idx_y),
    .dbank(dbank), .byte_off(byte_off), .addr(data_addr)
  );

  eag_stack #(.OFF_W(OFF_W), .PAGE(STK_PAGE)) u_stk (
    .sp_q(sp_q), .emu(emu), .op(sop), .ext(stk_ext), .operand(operand),
    .sp_d(sp_d), .sp_en(sp_en), .stk_addr(stk_addr)
  );

  eag_pc #(.OFF_W(OFF_W), .REL_W(8)) u_pc (
    .pc_q(pc_q), .op(pop), .operand(operand), .pc_d(pc_d), .pc_en(pc_en)
  );

  always_comb begin
    prg_off = pc_q + OFF_W'(byte_off);
    unique case (mode)
      AM_ABS, AM_ABSX, AM_ABSY, AM_PTR: addr = data_addr;
      AM_STK:  addr = {{BANK_W{1'b0}}, stk_addr};
      AM_PRG:  addr = {pbank, prg_off};
      default: addr = '0;
    endcase
    if (mode == AM_ABSX && rmw)     fixed_cyc = CYC_RMW_IDX;
    else if (mode == AM_PTR && emu) fixed_cyc = CYC_PTR_EMU;
    else                            fixed_cyc = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_RST;
      pc_q <= '0;
    end else begin
      if (sp_en) sp_q <= sp_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  assign sp_out = sp_q;
  assign pc_out = pc_q;
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode_sel,
  input logic        emu,
  input logic [1:0]  stk_op,
  input logic        stk_ext,
  input logic [1:0]  pc_op,
  input logic        rmw,
  input logic [7:0]  pbank,
  input logic [23:0] addr,
  input logic [15:0] sp_out,
  input logic [15:0] pc_out,
  input logic [2:0]  fixed_cyc
);
  p_prog_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 3'd5 |-> addr[23:16] == pbank);

  p_pc_inc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 2'd1 |=> pc_out == $past(pc_out) + 16'd1);

  p_stack_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 3'd4 |-> addr[23:16] == 8'h00);

  p_emu_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emu |=> sp_out[15:8] == 8'h01);

  p_page_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emu && stk_op == 2'd2 && !stk_ext && sp_out[15:8] == 8'h01)
      |=> sp_out == {8'h01, $past(sp_out[7:0]) + 8'd1});

  p_native_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu && stk_op == 2'd1) |=> sp_out == $past(sp_out) - 16'd1);

  p_rmw_cyc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd1 && rmw) |-> fixed_cyc == 3'd7);
endmodule

bind eag_top eag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .emu(emu),
  .stk_op(stk_op), .stk_ext(stk_ext), .pc_op(pc_op), .rmw(rmw),
  .pbank(pbank), .addr(addr), .sp_out(sp_out), .pc_out(pc_out),
  .fixed_cyc(fixed_cyc)
);

// File: tb/sim_eag_top.sv
module sim_eag_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode_sel;
  logic [15:0] operand, idx_x, idx_y;
  logic [7:0]  dbank, pbank;
  logic        emu;
  logic [1:0]  byte_off, stk_op, pc_op;
  logic        stk_ext, rmw;
  logic [23:0] addr;
  logic [15:0] sp_out, pc_out;
  logic [2:0]  fixed_cyc;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] ref_sp;
  logic [15:0] ref_pc;

  always #5 clk = ~clk;

  eag_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .operand(operand),
    .idx_x(idx_x), .idx_y(idx_y), .dbank(dbank), .pbank(pbank), .emu(emu),
    .byte_off(byte_off), .stk_op(stk_op), .stk_ext(stk_ext), .pc_op(pc_op),
    .rmw(rmw), .addr(addr), .sp_out(sp_out), .pc_out(pc_out),
    .fixed_cyc(fixed_cyc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    stk_op = 2'd0; pc_op = 2'd0; rmw = 1'b0; byte_off = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
    @(negedge clk);
  endtask

  // Stack step with a reference model built from R6, R7, R8.
  task automatic stk_step(input logic [1:0] op, input logic ext, input logic [15:0] ld, input string req);
    logic [15:0] eff, nxt, a;
    eff = emu ? {8'h01, ref_sp[7:0]} : ref_sp;
    nxt = eff; a = eff;
    if (op == 2'd1) begin
      a = eff;
      nxt = (emu && !ext) ? {8'h01, eff[7:0] - 8'd1} : eff - 16'd1;
    end else if (op == 2'd2) begin
      nxt = (emu && !ext) ? {8'h01, eff[7:0] + 8'd1} : eff + 16'd1;
      a = nxt;
    end else if (op == 2'd3) nxt = ld;
    if (emu) nxt[15:8] = 8'h01;
    mode_sel = 3'd4; stk_op = op; stk_ext = ext; operand = ld;
    #1;
    if (op != 2'd3) chk(req, {8'h00, addr}, {8'h00, 8'h00, a});
    tick();
    ref_sp = nxt;
    chk(req, {16'h0, sp_out}, {16'h0, ref_sp});
  endtask

  task automatic pc_step(input logic [1:0] op, input logic [15:0] v);
    logic [15:0] rel;
    rel = {{8{v[7]}}, v[7:0]};
    case (op)
      2'd1: ref_pc = ref_pc + 16'd1;
      2'd2: ref_pc = ref_pc + rel;
      2'd3: ref_pc = v;
      default: ;
    endcase
    pc_op = op; operand = v;
    tick();
    chk("R4 pc", {16'h0, pc_out}, {16'h0, ref_pc});
    mode_sel = 3'd5;
    for (int o = 0; o < 4; o++) begin
      byte_off = 2'(o); #1;
      chk("R4 prog addr", {8'h0, addr}, {8'h0, pbank, 16'(ref_pc + 16'(o))});
    end
    byte_off = 2'd0;
  endtask

  logic [15:0] ops [5];
  logic [15:0] ixs [4];
  logic [7:0]  bks [3];

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    ops[0] = 16'h0000; ops[1] = 16'h00FF; ops[2] = 16'h12FF; ops[3] = 16'hFFFE; ops[4] = 16'hFFFF;
    ixs[0] = 16'h0000; ixs[1] = 16'h0001; ixs[2] = 16'h00FF; ixs[3] = 16'hFFFF;
    bks[0] = 8'h00; bks[1] = 8'h12; bks[2] = 8'hFF;
    rst_n = 1'b0; mode_sel = 3'd0; operand = '0; idx_x = '0; idx_y = '0;
    dbank = '0; pbank = 8'h34; emu = 1'b1; stk_ext = 1'b0; idle();
    @(negedge clk); @(negedge clk);
    chk("R10 sp reset", {16'h0, sp_out}, 32'h01FF);
    chk("R10 pc reset", {16'h0, pc_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R9: sweep of data address forms
    for (int b = 0; b < 3; b++)
      for (int p = 0; p < 5; p++)
        for (int i = 0; i < 4; i++)
          for (int o = 0; o < 4; o++) begin
            dbank = bks[b]; operand = ops[p]; idx_x = ixs[i]; idx_y = ixs[3-i];
            byte_off = 2'(o);
            mode_sel = 3'd0; #1;
            chk("R1 abs", {8'h0, addr}, ({8'h0, bks[b], ops[p]} + o) & 32'hFFFFFF);
            mode_sel = 3'd1; rmw = 1'b1; #1;
            chk("R2 absx", {8'h0, addr}, ({8'h0, bks[b], ops[p]} + ixs[i] + o) & 32'hFFFFFF);
            chk("R9 rmw cyc", {29'h0, fixed_cyc}, 32'd7);
            mode_sel = 3'd2; #1;
            chk("R2 absy", {8'h0, addr}, ({8'h0, bks[b], ops[p]} + ixs[3-i] + o) & 32'hFFFFFF);
            chk("R9 absy cyc", {29'h0, fixed_cyc}, 32'd0);
            rmw = 1'b0;
            mode_sel = 3'd3; emu = i[0]; #1;
            chk("R3 ptr", {8'h0, addr}, {16'h0, 16'(ops[p] + 16'(o))});
            chk("R3 ptr cyc", {29'h0, fixed_cyc}, i[0] ? 32'd5 : 32'd0);
          end
    dbank = 8'h12; operand = 16'hFFFF; byte_off = 2'd1; mode_sel = 3'd0; #1;
    chk("R1 bank carry", {8'h0, addr}, 32'h130000);
    operand = 16'h12FF; mode_sel = 3'd3; #1;
    chk("R3 pointer high byte", {8'h0, addr}, 32'h001300);
    idle(); emu = 1'b1;
    @(negedge clk);

    // R4: program counter wrap
    ref_pc = 16'h0000;
    pc_step(2'd3, 16'hFFFE);
    pc_step(2'd1, 16'h0);
    pc_step(2'd1, 16'h0);
    pc_step(2'd2, 16'h00FC);
    pc_step(2'd3, 16'hFFF0);
    pc_step(2'd2, 16'h007F);
    pc_step(2'd0, 16'h0);

    // R5 R6 R7: emulation stack
    emu = 1'b1; ref_sp = 16'h01FF;
    stk_step(2'd3, 1'b0, 16'h3400, "R5 load forced page");
    stk_step(2'd1, 1'b0, 16'h0, "R6 push wrap");
    stk_step(2'd2, 1'b0, 16'h0, "R6 pull wrap");
    stk_step(2'd2, 1'b0, 16'h0, "R6 pull");
    stk_step(2'd3, 1'b0, 16'h0100, "R5 load");
    stk_step(2'd1, 1'b1, 16'h0, "R7 ext push");
    stk_step(2'd2, 1'b1, 16'h0, "R7 ext pull");
    chk("R7 ext pull ends at page", {16'h0, sp_out}, 32'h0100);
    stk_step(2'd2, 1'b1, 16'h0, "R7 ext pull mid");
    for (int k = 0; k < 260; k++) stk_step(2'd1, k[0], 16'h0, "R6 R7 push run");

    // R8: native stack
    emu = 1'b0;
    stk_step(2'd3, 1'b0, 16'h0000, "R8 load");
    stk_step(2'd1, 1'b0, 16'h0, "R8 push wrap");
    stk_step(2'd2, 1'b1, 16'h0, "R8 pull wrap");
    stk_step(2'd3, 1'b0, 16'h0100, "R8 load 0100");
    for (int k = 0; k < 8; k++) stk_step(2'd1, 1'b0, 16'h0, "R8 push below page");
    stk_step(2'd3, 1'b0, 16'h3456, "R8 load full");
    // R5: reentering emulation pins the page
    emu = 1'b1; mode_sel = 3'd0;
    tick();
    chk("R5 page pinned", {16'h0, sp_out}, 32'h0156);
    ref_sp = 16'h0156;
    stk_step(2'd2, 1'b0, 16'h0, "R5 R6 pull after entry");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule